// File: doc/BRIEF.md
# Digital Gain Output Stage

This stage sits after a decimating filter chain. It scales each 24-bit filtered sample by a digital gain between 1 and 4 (0 dB to 12 dB) and returns a saturated 16-bit word. At maximum gain the 16-bit window sits two bits below the top of the 24-bit word. At unity gain it is the top 16 bits. Quiet signals therefore keep 12 dB more resolution above the truncation floor of the narrower output.

The gain is steered by a small loop that runs once per processed sample. The level it acts on is the larger of two values. One is a magnitude supplied by the early decimator alongside each sample. The other is the magnitude of the stage's own saturated output. Above an upper threshold the gain steps down, and below a lower threshold it steps up. Between the two thresholds it holds.

When the gain has already reached unity and the level is still too high, the stage raises a handoff flag. The front-end attenuation controller uses this flag to take over and reduce gain further by analog means. Because the stage starts at a gain of 4, loop action begins 12 dB below the point where the front end alone would react.

Top module: `dgain_stage`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is 0, `gain_code` is 256 (gain 4) and `handoff` is 0.
- R2: `out_valid` is a one-cycle pulse exactly two clock cycles after each accepted `in_valid`. Between pulses `out_data` holds its last value.
- R3: `gain_code` is an unsigned gain with 6 fraction bits (64 = 1.0, 256 = 4.0). `out_data` equals floor(`in_data` × `gain_code` / 2^14), where `in_data` is taken as signed two's complement.
- R4: With `gain_code` 256, an in-range output equals `in_data[21:6]`. With `gain_code` 64, it equals `in_data[23:8]`.
- R5: Results above 32767 saturate to 32767, and results below -32768 saturate to -32768.
- R6: The loop level is max(`in_pre_mag`, |`out_data`|) of the same sample, where |-32768| = 32768. A level above 16384 lowers `gain_code` by 8, but not below 64.
- R7: A level below 8192 raises `gain_code` by 8, but not above 256.
- R8: A level from 8192 to 16384 inclusive leaves `gain_code` unchanged.
- R9: `handoff` is set with an output sample when `gain_code` was already 64 and the level is above 16384; `gain_code` then stays at 64. Any other output sample clears `handoff`. The flag holds between samples.
- R10: `gain_code` and `handoff` change only on the cycle `out_valid` is high. The new gain applies to samples accepted after that cycle, which requires `in_valid` pulses to be at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed filtered sample |
| in_pre_mag | input | 16 | Early-decimator magnitude for this sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Signed scaled, saturated sample |
| gain_code | output | 9 | Current gain, 6 fraction bits |
| handoff | output | 1 | Request for front-end attenuation |

## Verification
The hardest condition to reach from the ports is the handoff state. Getting there takes more than twenty consecutive loud samples to walk the gain down to unity, plus a further loud sample after that. Directed runs push the gain to unity twice. The first run is driven by a large early-decimator magnitude with zero data. The second is driven by a large output alone, which shows that either estimate can win. Constrained-random samples of widely varying amplitude then sweep the gain through its whole range, with a reference model tracking the gain across samples.

// File: rtl/dgain_pkg.sv
package dgain_pkg;

    typedef enum logic [1:0] {
        ZONE_QUIET = 2'd0,
        ZONE_HOLD  = 2'd1,
        ZONE_LOUD  = 2'd2
    } zone_e;

endpackage

// File: rtl/dgain_mult.sv
module dgain_mult #(
    parameter int IN_W = 24,
    parameter int GW   = 9
) (
    input  logic signed [IN_W-1:0]    din,
    input  logic        [GW-1:0]      gain,
    output logic signed [IN_W+GW:0]   prod
);

    logic signed [GW:0] gain_s;

    always_comb begin
        gain_s = $signed({1'b0, gain});
        prod   = din * gain_s;
    end

endmodule

// File: rtl/dgain_window.sv
module dgain_window #(
    parameter int PROD_W = 34,
    parameter int OUT_W  = 16,
    parameter int SHIFT  = 14
) (
    input  logic signed [PROD_W-1:0] prod,
    output logic signed [OUT_W-1:0]  dout,
    output logic        [OUT_W:0]    mag
);

    localparam int HI_W = PROD_W - OUT_W + 1;

    logic signed [PROD_W-1:0] shifted;
    logic        [HI_W-1:0]   hi_bits;
    logic signed [OUT_W:0]    ext;
    logic signed [OUT_W:0]    neg;

    always_comb begin
        shifted = prod >>> SHIFT;
        hi_bits = shifted[PROD_W-1:OUT_W-1];
        if ((&hi_bits) || !(|hi_bits)) begin
            dout = shifted[OUT_W-1:0];
        end else if (shifted[PROD_W-1]) begin
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        end
        ext = {dout[OUT_W-1], dout};
        neg = -ext;
        mag = ext[OUT_W] ? neg : ext;
    end

endmodule

// File: rtl/dgain_ctrl.sv
module dgain_ctrl
    import dgain_pkg::*;
#(
    parameter int GW     = 9,
    parameter int PRE_W  = 16,
    parameter int LVL_W  = 17,
    parameter int UNITY  = 64,
    parameter int GMAX   = 256,
    parameter int STEP   = 8,
    parameter int LVL_HI = 16384,
    parameter int LVL_LO = 8192
) (
    input  logic [GW-1:0]    gain,
    input  logic [PRE_W-1:0] pre_mag,
    input  logic [LVL_W-1:0] out_mag,
    output logic [GW-1:0]    gain_nxt,
    output logic             handoff_nxt
);

    localparam logic [GW:0]      UNITY_C = (GW+1)'(UNITY);
    localparam logic [GW:0]      GMAX_C  = (GW+1)'(GMAX);
    localparam logic [GW:0]      STEP_C  = (GW+1)'(STEP);
    localparam logic [LVL_W-1:0] HI_C    = LVL_W'(LVL_HI);
    localparam logic [LVL_W-1:0] LO_C    = LVL_W'(LVL_LO);

    logic [LVL_W-1:0] pre_ext;
    logic [LVL_W-1:0] level;
    logic [GW:0]      g_ext;
    logic [GW:0]      g_up;
    zone_e            zone;

    always_comb begin
        pre_ext = LVL_W'(pre_mag);
        level   = (pre_ext > out_mag) ? pre_ext : out_mag;
        if (level > HI_C) begin
            zone = ZONE_LOUD;
        end else if (level < LO_C) begin
            zone = ZONE_QUIET;
        end else begin
            zone = ZONE_HOLD;
        end

        g_ext       = {1'b0, gain};
        g_up        = g_ext + STEP_C;
        gain_nxt    = gain;
        handoff_nxt = 1'b0;
        unique case (zone)
            ZONE_LOUD: begin
                if (g_ext <= UNITY_C) begin
                    gain_nxt    = UNITY_C[GW-1:0];
                    handoff_nxt = 1'b1;
                end else if (g_ext <= UNITY_C + STEP_C) begin
                    gain_nxt = UNITY_C[GW-1:0];
                end else begin
                    gain_nxt = gain - STEP_C[GW-1:0];
                end
            end
            ZONE_QUIET: begin
                gain_nxt = (g_up >= GMAX_C) ? GMAX_C[GW-1:0] : g_up[GW-1:0];
            end
            default: gain_nxt = gain;
        endcase
    end

endmodule

// File: rtl/dgain_stage.sv
module dgain_stage #(
    parameter int IN_W   = 24,
    parameter int OUT_W  = 16,
    parameter int PRE_W  = 16,
    parameter int FRAC   = 6,
    parameter int STEP   = 8,
    parameter int LVL_HI = 16384,
    parameter int LVL_LO = 8192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic [PRE_W-1:0]        in_pre_mag,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_data,
    output logic [FRAC+2:0]         gain_code,
    output logic                    handoff
);

    localparam int GW     = FRAC + 3;
    localparam int PROD_W = IN_W + GW + 1;
    localparam int SHIFT  = (IN_W - OUT_W) + FRAC;
    localparam int LVL_W  = OUT_W + 1;
    localparam int UNITY  = 1 << FRAC;
    localparam int GMAX   = 4 << FRAC;

    typedef struct packed {
        logic                     s1_vld;
        logic signed [PROD_W-1:0] s1_prod;
        logic [PRE_W-1:0]         s1_pre;
        logic                     o_vld;
        logic signed [OUT_W-1:0]  o_data;
        logic [GW-1:0]            gain;
        logic                     handoff;
    } st_t;

    st_t st_d, st_q;

    logic signed [PROD_W-1:0] prod;
    logic signed [OUT_W-1:0]  win_out;
    logic [LVL_W-1:0]         win_mag;
    logic [GW-1:0]            gain_nxt;
    logic                     handoff_nxt;

    dgain_mult #(.IN_W(IN_W), .GW(GW)) u_mult (
        .din  (in_data),
        .gain (st_q.gain),
        .prod (prod)
    );

    dgain_window #(.PROD_W(PROD_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_window (
        .prod (st_q.s1_prod),
        .dout (win_out),
        .mag  (win_mag)
    );

    dgain_ctrl #(
        .GW(GW), .PRE_W(PRE_W), .LVL_W(LVL_W), .UNITY(UNITY), .GMAX(GMAX),
        .STEP(STEP), .LVL_HI(LVL_HI), .LVL_LO(LVL_LO)
    ) u_ctrl (
        .gain        (st_q.gain),
        .pre_mag     (st_q.s1_pre),
        .out_mag     (win_mag),
        .gain_nxt    (gain_nxt),
        .handoff_nxt (handoff_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            st_d.s1_prod = prod;
            st_d.s1_pre  = in_pre_mag;
        end
        st_d.o_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.o_data  = win_out;
            st_d.gain    = gain_nxt;
            st_d.handoff = handoff_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.gain    <= GW'(GMAX);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_vld;
    assign out_data  = st_q.o_data;
    assign gain_code = st_q.gain;
    assign handoff   = st_q.handoff;

endmodule

// File: rtl/dgain_stage_chk.sv
module dgain_stage_chk #(
    parameter int GW    = 9,
    parameter int OUT_W = 16,
    parameter int UNITY = 64,
    parameter int GMAX  = 256
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_data,
    input logic [GW-1:0]           gain_code,
    input logic                    handoff
);

    localparam logic [GW-1:0] UNITY_C = GW'(UNITY);
    localparam logic [GW-1:0] GMAX_C  = GW'(GMAX);

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R10
    gain_moves_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != $past(gain_code)) |-> out_valid);

    // R6
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code >= UNITY_C) && (gain_code <= GMAX_C));

    // R9
    handoff_at_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |-> (gain_code == UNITY_C));

    // R9
    handoff_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(handoff) |-> (out_valid && $past(gain_code) == UNITY_C));

endmodule

bind dgain_stage dgain_stage_chk #(
    .GW(GW), .OUT_W(OUT_W), .UNITY(UNITY), .GMAX(GMAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .gain_code (gain_code),
    .handoff   (handoff)
);

// File: tb/dgain_stage_bench.sv
`timescale 1ns/1ps
module dgain_stage_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_data = '0;
    logic [15:0]        in_pre_mag = '0;
    logic               out_valid;
    logic signed [15:0] out_data;
    logic [8:0]         gain_code;
    logic               handoff;

    int checks = 0;
    int failures = 0;
    int g_model = 256;
    int h_model = 0;
    int last_out = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dgain_stage u_dgain_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_pre_mag (in_pre_mag),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .gain_code  (gain_code),
        .handoff    (handoff)
    );

    function automatic int exp_out(input logic signed [23:0] d, input int g);
        longint p;
        p = longint'(d) * longint'(g);
        p = p >>> 14;
        if (p > 32767) p = 32767;
        if (p < -32768) p = -32768;
        return int'(p);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic signed [23:0] d, input logic [15:0] pre, input string req);
        int eo, mag, lvl;
        @(negedge clk);
        check("R2", "idle valid", int'(out_valid), 0);
        check("R2", "held data", int'(out_data), last_out);
        in_valid = 1'b1;
        in_data = d;
        in_pre_mag = pre;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "valid after 1 cycle", int'(out_valid), 0);
        @(negedge clk);
        eo = exp_out(d, g_model);
        mag = (eo < 0) ? -eo : eo;
        lvl = (int'(pre) > mag) ? int'(pre) : mag;
        if (lvl > 16384) begin
            if (g_model == 64) h_model = 1;
            else begin
                h_model = 0;
                g_model = (g_model - 8 < 64) ? 64 : g_model - 8;
            end
        end else begin
            h_model = 0;
            if (lvl < 8192) g_model = (g_model + 8 > 256) ? 256 : g_model + 8;
        end
        check("R2", "valid after 2 cycles", int'(out_valid), 1);
        check(req, "out_data", int'(out_data), eo);
        check(req, "gain_code", int'(gain_code), g_model);
        check(req, "handoff", int'(handoff), h_model);
        last_out = eo;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r, sh, gap;
        logic signed [23:0] d;
        logic [15:0] p;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "out_data", int'(out_data), 0);
        check("R1", "gain_code", int'(gain_code), 256);
        check("R1", "handoff", int'(handoff), 0);

        // R4 / R7: gain 4 window, quiet level keeps gain clamped at 256
        send(24'sh001234, 16'd0, "R4");
        check("R4", "window at gain 4", int'(out_data), 72);
        check("R7", "clamp at max", int'(gain_code), 256);
        // R5 positive and negative saturation, R6 step down
        send(24'sh3FFFFF, 16'd0, "R5");
        check("R5", "positive saturation", int'(out_data), 32767);
        check("R6", "step down", int'(gain_code), 248);
        send(-24'sh400000, 16'd0, "R5");
        check("R5", "negative saturation", int'(out_data), -32768);
        // R6 early estimate alone walks gain to unity
        while (g_model > 64) send(24'sh0, 16'hFFFF, "R6");
        check("R6", "floor at unity", int'(gain_code), 64);
        check("R9", "no handoff on arrival", int'(handoff), 0);
        // R9 and R4: unity window with handoff
        send(24'sh123456, 16'hFFFF, "R9");
        check("R4", "window at gain 1", int'(out_data), 16'sh1234);
        check("R9", "handoff set", int'(handoff), 1);
        check("R9", "gain held", int'(gain_code), 64);
        // R8 hold band at both edges
        send(24'sh0, 16'd8192, "R8");
        check("R9", "handoff cleared", int'(handoff), 0);
        send(24'sh0, 16'd16384, "R8");
        check("R8", "gain held in band", int'(gain_code), 64);
        // R7 quiet raises gain
        send(24'sh0, 16'd0, "R7");
        check("R7", "step up", int'(gain_code), 72);
        // R6 output magnitude alone drives gain down to handoff
        while (h_model == 0) send(24'sh600000, 16'd0, "R6");
        check("R9", "handoff from output level", int'(handoff), 1);
        // R3 random amplitudes with random gaps (R10)
        for (int i = 0; i < 600; i++) begin
            sh = $urandom_range(0, 23);
            r = $urandom;
            d = 24'(r) >>> sh;
            p = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 9000));
            gap = $urandom_range(0, 2);
            repeat (gap) @(negedge clk);
            send(d, p, "R3");
        end
        send(24'sh0, 16'd0, "R10");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule